// File: doc/BRIEF.md
# Posted-Write Fault Recorder

This block sits beside the path that carries posted accesses from the processor toward I/O devices. It follows one access at a time, from its start event to its completion event. An access fails when the device answers with an error acknowledge, when the device completes but then reports an error late, or when no completion arrives within a fixed number of clock cycles. The first failure is kept with its full context in a status register and a fault-address register. Any failure after that, while the first one is still held, only raises a multiple-error flag.

Software reads both registers through a small register port. It clears the record by writing a one to the summary bit of the status register. The timeout limit is a parameter counted in clock cycles. Its default of 640 cycles gives 12.8 µs at a 50 MHz clock. Once a timeout has closed an access, a completion that arrives later for that access is dropped.

Top module: `wfault_recorder`

## Requirements
- R1: Status bit 31 (summary) is 1 exactly when one of the cause bits 30, 29 or 28 is 1.
- R2: A completion with acknowledge code 1 sets bit 28 (error acknowledge). Code 2 sets bit 30 (late error report). Codes 0 and 3 record nothing.
- R3: An access with no completion on any of the TMO_CYCLES clock edges after its start edge sets bit 29 (timeout). A completion on the last of those edges counts as a completion, not as a timeout.
- R4: On the first failure the block captures the failing access's context. The size code goes to bits 27:25, the supervisor flag to bit 24, and the read flag to bit 18. Bit 17 (address valid) is set, and the fault-address register (reg_sel=1) takes the access address.
- R5: Status bits 23:20 always read 4'h8, both from reset and after any write.
- R6: A failure that occurs while bit 31 is set only sets bit 19 (multiple). The cause bits, the context fields and the fault address are left unchanged.
- R7: Writing the status register (reg_sel=0) with bit 31 set clears bits 31:24, 19, 18 and 17, but keeps the fault address. A status write with bit 31 clear has no effect. A write to the fault-address register has no effect.
- R8: A completion that arrives while no access is open is ignored, including one that arrives after a timeout. A start that arrives while an access is open is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_start | input | 1 | Start event of an access |
| acc_read | input | 1 | Access is a read (1) or a write (0) |
| acc_addr | input | ADDR_W | Physical address of the access |
| acc_size | input | 3 | Size code of the access |
| acc_super | input | 1 | Processor was in supervisor mode |
| acc_done | input | 1 | Completion event of the open access |
| acc_ack | input | 2 | Acknowledge code qualified by acc_done |
| reg_sel | input | 1 | Register select: 0 status, 1 fault address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |

## Verification
The tracking state is visible only through the two registers. A timer that is off by one moves the boundary between a late completion and a timeout. That shows as bit 29 instead of bit 28 when an access completes exactly on the limit. An open flag that stays stuck shows at the ports as a second timeout, or as a stray completion being recorded as an error. A capture register that reloads when it should hold shows up the first time a second error arrives after a different access. The bench therefore reads both registers after every access, clear and stray event, so a wrong state shows within the same access in which it arises.

// File: rtl/wfr_pkg.sv
// Shared types and field positions for the posted-write fault recorder.
// Assumes a 32-bit register port.
package wfr_pkg;

    localparam int DATA_W   = 32;
    localparam int SIZE_W   = 3;
    localparam int ACK_W    = 2;
    localparam int SUM_BIT  = 31;
    localparam logic [3:0] RSV_VALUE = 4'h8;

    // Acknowledge code carried with a completion event
    typedef enum logic [ACK_W-1:0] {
        ACK_OK     = 2'd0,
        ACK_BUSERR = 2'd1,
        ACK_LATE   = 2'd2,
        ACK_SPARE  = 2'd3
    } ack_e;

    // Reason for a recorded failure
    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_LATE   = 2'd1,
        CAUSE_TMO    = 2'd2,
        CAUSE_BUSERR = 2'd3
    } cause_e;

    // Context of the access that is being tracked
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic              sup;
        logic              rd;
    } ctx_t;

    // Status register state, kept as separate flops
    typedef struct packed {
        logic              sum;
        logic              late;
        logic              tmo;
        logic              buserr;
        logic [SIZE_W-1:0] size;
        logic              sup;
        logic              multi;
        logic              rd;
        logic              valid;
    } stat_t;

endpackage

// File: rtl/wfr_tracker.sv
// Follows one access from its start to its completion and times it.
// Raises a one-cycle failure event carrying the access context.
// Assumes at most one access is open; a start seen while busy is dropped.
module wfr_tracker
    import wfr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TMO_CYCLES = 640,
    localparam int CNT_W     = $clog2(TMO_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              read_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              super_i,
    input  logic              done_i,
    input  logic [ACK_W-1:0]  ack_i,
    output logic              fire_o,
    output cause_e            cause_o,
    output logic [ADDR_W-1:0] fault_addr_o,
    output ctx_t              fault_ctx_o,
    output logic              busy_o,
    output logic [CNT_W-1:0]  cnt_o
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    ctx_t              ctx_q;
    logic              expire;

    assign expire = busy_q && !done_i && (cnt_q == LAST);

    // Decide whether the current cycle closes the open access with a failure
    always_comb begin
        fire_o  = 1'b0;
        cause_o = CAUSE_NONE;
        if (busy_q && done_i) begin
            unique case (ack_e'(ack_i))
                ACK_BUSERR: begin fire_o = 1'b1; cause_o = CAUSE_BUSERR; end
                ACK_LATE:   begin fire_o = 1'b1; cause_o = CAUSE_LATE;   end
                default:    begin fire_o = 1'b0; cause_o = CAUSE_NONE;   end
            endcase
        end else if (expire) begin
            fire_o  = 1'b1;
            cause_o = CAUSE_TMO;
        end
    end

    // Open, time and close the tracked access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            addr_q <= '0;
            ctx_q  <= '0;
        end else if (busy_q) begin
            if (done_i || expire) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start_i) begin
            busy_q     <= 1'b1;
            cnt_q      <= '0;
            addr_q     <= addr_i;
            ctx_q.size <= size_i;
            ctx_q.sup  <= super_i;
            ctx_q.rd   <= read_i;
        end
    end

    assign fault_addr_o = addr_q;
    assign fault_ctx_o  = ctx_q;
    assign busy_o       = busy_q;
    assign cnt_o        = cnt_q;

endmodule

// File: rtl/wfr_capture.sv
// Holds the status flags and the fault address.
// The first failure loads the full context; later ones only mark "multiple".
// A clear in the same cycle as a failure is applied first, so that failure
// becomes the new first record.
module wfr_capture
    import wfr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  cause_e            cause_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  ctx_t              ctx_i,
    input  logic              clr_i,
    output stat_t             stat_o,
    output logic [ADDR_W-1:0] far_o
);

    stat_t             stat_q, stat_d;
    logic [ADDR_W-1:0] far_q, far_d;

    // Next-state: apply the clear, then fold in a failure event
    always_comb begin
        stat_d = stat_q;
        far_d  = far_q;
        if (clr_i) begin
            stat_d = '0;
        end
        if (fire_i) begin
            if (!stat_d.sum) begin
                stat_d.sum    = 1'b1;
                stat_d.late   = (cause_i == CAUSE_LATE);
                stat_d.tmo    = (cause_i == CAUSE_TMO);
                stat_d.buserr = (cause_i == CAUSE_BUSERR);
                stat_d.size   = ctx_i.size;
                stat_d.sup    = ctx_i.sup;
                stat_d.rd     = ctx_i.rd;
                stat_d.valid  = 1'b1;
                far_d         = addr_i;
            end else begin
                stat_d.multi = 1'b1;
            end
        end
    end

    // Register the status flags and the fault address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            far_q  <= '0;
        end else begin
            stat_q <= stat_d;
            far_q  <= far_d;
        end
    end

    assign stat_o = stat_q;
    assign far_o  = far_q;

endmodule

// File: rtl/wfr_regport.sv
// Register port: the read multiplexer and the write decode.
// Only the clear-on-write of the summary bit has an effect; all other
// written bits, and writes to the address register, are dropped.
module wfr_regport
    import wfr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  stat_t             stat_i,
    input  logic [ADDR_W-1:0] far_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clr_o
);

    logic [DATA_W-1:0] status_word;

    // Assemble the status word from its fields
    always_comb begin
        status_word        = '0;
        status_word[31]    = stat_i.sum;
        status_word[30]    = stat_i.late;
        status_word[29]    = stat_i.tmo;
        status_word[28]    = stat_i.buserr;
        status_word[27:25] = stat_i.size;
        status_word[24]    = stat_i.sup;
        status_word[23:20] = RSV_VALUE;
        status_word[19]    = stat_i.multi;
        status_word[18]    = stat_i.rd;
        status_word[17]    = stat_i.valid;
    end

    // Select the register that is read
    always_comb begin
        rdata_o = sel_i ? DATA_W'(far_i) : status_word;
    end

    // Decode the write-one-to-clear of the summary bit
    always_comb begin
        clr_o = wr_i && !sel_i && wdata_i[SUM_BIT];
    end

endmodule

// File: rtl/wfault_recorder.sv
// Top level of the posted-write fault recorder.
// Connects the access tracker, the capture registers and the register port.
// Assumes ADDR_W <= 32 and TMO_CYCLES >= 1.
module wfault_recorder
    import wfr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TMO_CYCLES = 640,
    localparam int CNT_W     = $clog2(TMO_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_start,
    input  logic              acc_read,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [2:0]        acc_size,
    input  logic              acc_super,
    input  logic              acc_done,
    input  logic [1:0]        acc_ack,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);

    logic              fire;
    cause_e            cause;
    logic [ADDR_W-1:0] trk_addr;
    ctx_t              trk_ctx;
    logic              busy;
    logic [CNT_W-1:0]  cnt;
    stat_t             stat_q;
    logic [ADDR_W-1:0] far_q;
    logic              clr;

    wfr_tracker #(.ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .start_i(acc_start), .read_i(acc_read), .addr_i(acc_addr),
        .size_i(acc_size), .super_i(acc_super),
        .done_i(acc_done), .ack_i(acc_ack),
        .fire_o(fire), .cause_o(cause), .fault_addr_o(trk_addr),
        .fault_ctx_o(trk_ctx), .busy_o(busy), .cnt_o(cnt)
    );

    wfr_capture #(.ADDR_W(ADDR_W)) u_cap (
        .clk(clk), .rst_n(rst_n),
        .fire_i(fire), .cause_i(cause), .addr_i(trk_addr), .ctx_i(trk_ctx),
        .clr_i(clr), .stat_o(stat_q), .far_o(far_q)
    );

    wfr_regport #(.ADDR_W(ADDR_W)) u_reg (
        .sel_i(reg_sel), .wr_i(reg_wr), .wdata_i(reg_wdata),
        .stat_i(stat_q), .far_i(far_q),
        .rdata_o(reg_rdata), .clr_o(clr)
    );

endmodule

// File: rtl/wfr_checker.sv
// Property checker for the fault recorder, attached with bind.
// Observes the capture state, the failure event, the clear strobe and the timer.
module wfr_checker
    import wfr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int TMO_CYCLES = 640,
    localparam int CNT_W     = $clog2(TMO_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input stat_t             stat,
    input logic [ADDR_W-1:0] far,
    input logic              fire,
    input logic              clr,
    input logic              busy,
    input logic [CNT_W-1:0]  cnt
);

    // R1: the summary flop agrees with the cause flops
    a_r1_summary_matches_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stat.sum == (stat.late || stat.tmo || stat.buserr));

    // R2: at most one cause is held at a time
    a_r2_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stat.late, stat.tmo, stat.buserr}));

    // R3: the timer never passes the limit while an access is open
    a_r3_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(cnt) < TMO_CYCLES));

    // R4: the address-valid flag pairs with the summary
    a_r4_valid_with_summary: assert property (@(posedge clk) disable iff (!rst_n)
        stat.valid == stat.sum);

    // R6: a held record keeps its context unless cleared
    a_r6_context_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stat.sum && !clr) |=> ($stable(far) && $stable(stat.size) &&
                                $stable(stat.sup) && $stable(stat.rd)));

    // R6: a failure on top of a held record marks multiple
    a_r6_multi_set: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && stat.sum && !clr) |=> stat.multi);

    // R7: a clear with no failure in that cycle empties the record
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !fire) |=> (!stat.sum && !stat.multi && !stat.valid));

endmodule

bind wfault_recorder wfr_checker #(.ADDR_W(ADDR_W), .TMO_CYCLES(TMO_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat(stat_q), .far(far_q),
    .fire(fire), .clr(clr), .busy(busy), .cnt(cnt)
);

// File: tb/tb_wfault_recorder.sv
// Bench for the fault recorder: directed corners plus seeded random accesses.
// Inputs change at the falling edge; outputs are read before the next rising edge.
module tb_wfault_recorder;

    localparam int AW  = 32;
    localparam int TMO = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_start = 1'b0, acc_read = 1'b0, acc_super = 1'b0, acc_done = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [2:0]    acc_size = '0;
    logic [1:0]    acc_ack = '0;
    logic          reg_sel = 1'b0, reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference model of the register contents
    logic m_sum, m_le, m_to, m_be, m_sup, m_me, m_rd, m_fav;
    logic [2:0]  m_size;
    logic [31:0] m_addr;

    always #10 clk = ~clk;

    wfault_recorder #(.ADDR_W(AW), .TMO_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .acc_start(acc_start), .acc_read(acc_read), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_super(acc_super),
        .acc_done(acc_done), .acc_ack(acc_ack),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [31:0] exp_status();
        return {m_sum, m_le, m_to, m_be, m_size, m_sup, 4'h8,
                m_me, m_rd, m_fav, 17'd0};
    endfunction

    task automatic m_reset();
        {m_sum, m_le, m_to, m_be, m_sup, m_me, m_rd, m_fav} = '0;
        m_size = '0;
        m_addr = '0;
    endtask

    // kind: 1 late report, 2 timeout, 3 error acknowledge
    task automatic m_fail(int kind, logic rd, logic [31:0] a, logic [2:0] sz, logic sp);
        if (!m_sum) begin
            m_sum = 1'b1; m_le = (kind == 1); m_to = (kind == 2); m_be = (kind == 3);
            m_rd = rd; m_addr = a; m_size = sz; m_sup = sp; m_fav = 1'b1;
        end else begin
            m_me = 1'b1;
        end
    endtask

    task automatic m_clear();
        {m_sum, m_le, m_to, m_be, m_sup, m_me, m_rd, m_fav} = '0;
        m_size = '0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Read both registers through the port and compare against the model
    task automatic read_check(string req);
        reg_sel = 1'b0; #1;
        check({req, " status"}, reg_rdata, exp_status());
        reg_sel = 1'b1; #1;
        check({req, " address"}, reg_rdata, m_addr);
        reg_sel = 1'b0;
    endtask

    task automatic reg_write(logic sel, logic [31:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
        if (!sel && d[31]) m_clear();
    endtask

    task automatic stray_done(logic [1:0] ack);
        acc_done = 1'b1; acc_ack = ack;
        @(negedge clk);
        acc_done = 1'b0;
    endtask

    // One access: completion on the k-th edge after the start edge, or none if k > TMO
    task automatic access(logic rd, logic [31:0] a, logic [2:0] sz, logic sp, int k, logic [1:0] ack);
        acc_start = 1'b1; acc_read = rd; acc_addr = a; acc_size = sz; acc_super = sp;
        @(negedge clk);
        acc_start = 1'b0;
        if (k <= TMO) begin
            repeat (k - 1) @(negedge clk);
            acc_done = 1'b1; acc_ack = ack;
            @(negedge clk);
            acc_done = 1'b0;
            if (ack == 2'd1) m_fail(3, rd, a, sz, sp);
            else if (ack == 2'd2) m_fail(1, rd, a, sz, sp);
        end else begin
            repeat (TMO) @(negedge clk);
            m_fail(2, rd, a, sz, sp);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [31:0] seed_dummy;
        m_reset();
        seed_dummy = $urandom(32'h5EED1234);
        repeat (3) @(negedge clk);
        // R5 R1: reset state, reserved field reads 8
        read_check("R5 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R2: clean completion records nothing
        access(1'b0, 32'h1000_0040, 3'd2, 1'b0, 3, 2'd0);
        read_check("R2 ack ok");
        // R2 R4 R1: error acknowledge captures context
        access(1'b0, 32'hF00D_0008, 3'd5, 1'b1, 2, 2'd1);
        read_check("R2 R4 error ack");
        // R6: later late report only marks multiple
        access(1'b1, 32'h0BAD_0000, 3'd1, 1'b0, 1, 2'd2);
        read_check("R6 multiple");
        // R7: writes without the summary bit, and to the address register, do nothing
        reg_write(1'b0, 32'h7FFF_FFFF);
        read_check("R7 no clear");
        reg_write(1'b1, 32'hFFFF_FFFF);
        read_check("R7 addr write");
        // R7: clear
        reg_write(1'b0, 32'h8000_0000);
        read_check("R7 clear");
        // R3: timeout of a read; R8: late completion ignored
        access(1'b1, 32'h2222_3330, 3'd3, 1'b1, TMO + 1, 2'd0);
        read_check("R3 timeout");
        stray_done(2'd1);
        read_check("R8 after timeout");
        reg_write(1'b0, 32'h8000_0000);
        // R3: completion on the last edge is not a timeout
        access(1'b0, 32'h4444_0004, 3'd0, 1'b0, TMO, 2'd1);
        read_check("R3 boundary");
        reg_write(1'b0, 32'hFFFF_FFFF);
        // R8: start while busy ignored
        acc_start = 1'b1; acc_read = 1'b0; acc_addr = 32'hAAAA_0000; acc_size = 3'd6; acc_super = 1'b1;
        @(negedge clk);
        acc_start = 1'b0;
        @(negedge clk);
        acc_start = 1'b1; acc_read = 1'b1; acc_addr = 32'hBBBB_0000; acc_size = 3'd1; acc_super = 1'b0;
        @(negedge clk);
        acc_start = 1'b0;
        stray_done(2'd1);
        m_fail(3, 1'b0, 32'hAAAA_0000, 3'd6, 1'b1);
        read_check("R8 start while busy");
        reg_write(1'b0, 32'h8000_0000);
        // R2: code 3 records nothing, code 2 records a late report
        access(1'b0, 32'h5555_0000, 3'd7, 1'b0, 4, 2'd3);
        read_check("R2 spare code");
        stray_done(2'd2);
        read_check("R8 done while idle");
        access(1'b0, 32'h6666_0010, 3'd4, 1'b1, 5, 2'd2);
        read_check("R2 late report");

        // Random mix: R1 R2 R3 R4 R6 R7 R8
        for (int i = 0; i < 80; i++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 7) begin
                int k;
                logic [1:0] ack;
                k   = $urandom_range(1, TMO + 2);
                ack = 2'($urandom_range(0, 3));
                access(1'($urandom_range(0, 1)), $urandom, 3'($urandom_range(0, 7)),
                       1'($urandom_range(0, 1)), k, ack);
                read_check("R6 random access");
                if (k > TMO && $urandom_range(0, 1) == 1) begin
                    stray_done(2'd1);
                    read_check("R8 random stray");
                end
            end else begin
                reg_write(1'b0, {1'($urandom_range(0, 1)), 31'($urandom)});
                read_check("R7 random write");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule